// File: doc/BRIEF.md
# Write-Port Room Flag for a Dual-Clock FIFO

This block is the status logic on the write side of a FIFO whose two ports run from unrelated clocks. It keeps the write pointer, takes in a copy of the read pointer that has already been brought into the write clock domain, and drives one registered flag, `wr_room`. The flag serves both timing modes of the FIFO. In first-word-fall-through operation it is read as "input ready", and in standard operation its inverse is read as "full". In both modes, high means at least one storage location is free.

A write request is accepted only while the flag is high. An accepted write produces a one-cycle memory write strobe and advances the write pointer. Both pointers carry one extra wrap bit above the address bits, so the occupancy is their difference and covers the range 0 to DEPTH. The incoming read pointer passes through one more register stage before the comparison. As a result, a location freed by a read becomes writable on the second write-clock edge after the new pointer value appears. A write that takes the last free location drops the flag on the same edge.

Top module: `fifo_wr_gate`

## Requirements
- R1: While `rst_n` is low, `wr_room` is 0, `wr_ptr` is 0 and `wr_strobe` is 0.
- R2: With `rd_ptr_sync` at 0, the first rising clock edge after reset is released sets `wr_room` to 1.
- R3: `wr_strobe` is high exactly when `wr_en` is high and `wr_room` is high in the same cycle (an accepted write).
- R4: At each rising edge, `wr_ptr` advances by one, modulo 2^(ADDR_W+1), if a write was accepted, and otherwise holds its value.
- R5: A write accepted on the edge that brings the occupancy (`wr_ptr` minus the captured read pointer, modulo 2^(ADDR_W+1)) to DEPTH = 2^ADDR_W clears `wr_room` on that same edge.
- R6: While `wr_room` is low, `wr_en` is ignored: `wr_strobe` stays 0 and `wr_ptr` does not change.
- R7: When `rd_ptr_sync` changes before rising edge k and so frees a location, `wr_room` is still low after edge k and goes high after edge k+1.
- R8: The occupancy seen by the comparator never exceeds DEPTH, and `wr_room` is high exactly when the occupancy after that edge's write, measured against the read pointer captured one edge earlier, is below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the FIFO |
| wr_en | input | 1 | Write request |
| rd_ptr_sync | input | ADDR_W+1 | Read pointer with wrap bit, already synchronized to `clk` |
| wr_room | output | 1 | High when a location is free (input ready / not full) |
| wr_strobe | output | 1 | Memory write enable for the accepted write |
| wr_ptr | output | ADDR_W+1 | Write pointer with wrap bit; low ADDR_W bits address the memory |

## Verification
The bench builds the block with ADDR_W = 2, so the FIFO holds four words and the pointers are three bits wide. At that size, a few thousand cycles of pseudo-random writes and reads pass through every occupancy from empty to full many times. They also wrap both pointers repeatedly and hit the full, full-1 and full-2 classes on every pass. Directed sequences cover reset release, filling to the last word, requests while full, and the two-edge delay before a freed location is offered again.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    // Fill class of the FIFO as seen from the write side
    typedef enum logic [1:0] {
        LVL_ROOM  = 2'd0,
        LVL_FULL2 = 2'd1,
        LVL_FULL1 = 2'd2,
        LVL_FULL  = 2'd3
    } fill_lvl_e;

endpackage

// File: rtl/fwg_rd_capture.sv
module fwg_rd_capture #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_ptr_in,
    output logic [PW-1:0] rd_ptr_seen
);

    logic [PW-1:0] seen_d, seen_q;

    always_comb begin
        seen_d = rd_ptr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    assign rd_ptr_seen = seen_q;

endmodule

// File: rtl/fwg_fill_class.sv
module fwg_fill_class
    import fwg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W:0] wr_ptr,
    input  logic [ADDR_W:0] rd_ptr,
    output fill_lvl_e       level
);

    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    logic [PW-1:0] occ;

    always_comb begin
        occ = wr_ptr - rd_ptr;
        if (occ == DEPTH_P)                 level = LVL_FULL;
        else if (occ == DEPTH_P - PW'(1))   level = LVL_FULL1;
        else if (occ == DEPTH_P - PW'(2))   level = LVL_FULL2;
        else                                level = LVL_ROOM;
    end

endmodule

// File: rtl/fifo_wr_gate.sv
module fifo_wr_gate
    import fwg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ADDR_W:0] rd_ptr_sync,
    output logic            wr_room,
    output logic            wr_strobe,
    output logic [ADDR_W:0] wr_ptr
);

    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic          room;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] rd_seen_q;
    fill_lvl_e     level;
    logic          accept;

    fwg_rd_capture #(.PW(PW)) i_rd_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_ptr_in   (rd_ptr_sync),
        .rd_ptr_seen (rd_seen_q)
    );

    fwg_fill_class #(.ADDR_W(ADDR_W)) i_fill_class (
        .wr_ptr (st_q.wptr),
        .rd_ptr (rd_seen_q),
        .level  (level)
    );

    always_comb begin
        accept  = wr_en && st_q.room;
        st_d    = st_q;
        st_d.wptr = st_q.wptr + PW'(accept);
        case (level)
            LVL_FULL:  st_d.room = 1'b0;
            LVL_FULL1: st_d.room = !accept;
            default:   st_d.room = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wptr <= '0;
            st_q.room <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_room   = st_q.room;
    assign wr_strobe = accept;
    assign wr_ptr    = st_q.wptr;

endmodule

// File: rtl/fwg_chk.sv
module fwg_chk #(
    parameter int ADDR_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_room,
    input logic            wr_strobe,
    input logic [ADDR_W:0] wr_ptr,
    input logic [ADDR_W:0] rd_seen
);

    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

    // R3
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (wr_room && wr_en));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wr_ptr == $past(wr_ptr) + PW'($past(wr_strobe))));

    // R6
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_room && wr_en) |=> (wr_ptr == $past(wr_ptr)));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && (PW'(wr_ptr + PW'(1) - rd_seen) == DEPTH_P)) |=> !wr_room);

    // R8
    occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(wr_ptr - rd_seen) <= DEPTH_P);

endmodule

bind fifo_wr_gate fwg_chk #(.ADDR_W(ADDR_W)) i_fwg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_room   (wr_room),
    .wr_strobe (wr_strobe),
    .wr_ptr    (wr_ptr),
    .rd_seen   (rd_seen_q)
);

// File: tb/test_fifo_wr_gate.sv
module test_fifo_wr_gate;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 2;
    localparam int PW         = ADDR_W + 1;
    localparam int DEPTH      = 1 << ADDR_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [PW-1:0] rd_ptr_sync = '0;
    logic          wr_room;
    logic          wr_strobe;
    logic [PW-1:0] wr_ptr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic          flag_exp = 1'b0;
    logic [PW-1:0] wexp = '0;
    logic [PW-1:0] rdq_exp = '0;
    logic [15:0]   lfsr = 16'hACE1;

    fifo_wr_gate #(.ADDR_W(ADDR_W)) i_fifo_wr_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_ptr_sync (rd_ptr_sync),
        .wr_room     (wr_room),
        .wr_strobe   (wr_strobe),
        .wr_ptr      (wr_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a negedge: drive, check strobe, clock, update model, check state
    task automatic step(input logic we, input logic [PW-1:0] rp, input string ftag);
        logic          acc;
        logic [PW-1:0] occ;
        wr_en = we;
        rd_ptr_sync = rp;
        #1;
        chk(wr_strobe == (we && flag_exp), "R3/R6 strobe", int'(wr_strobe), int'(we && flag_exp));
        @(posedge clk);
        acc = we && flag_exp;
        wexp = wexp + PW'(acc);
        occ = wexp - rdq_exp;
        flag_exp = (occ != PW'(DEPTH));
        rdq_exp = rp;
        @(negedge clk);
        chk(wr_ptr == wexp, "R4 pointer", int'(wr_ptr), int'(wexp));
        chk(wr_room == flag_exp, ftag, int'(wr_room), int'(flag_exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [PW-1:0] rp;
        // R1: reset state
        repeat (3) @(negedge clk);
        wr_en = 1'b1;
        #1;
        chk(wr_room == 1'b0, "R1 room", int'(wr_room), 0);
        chk(wr_ptr == '0, "R1 ptr", int'(wr_ptr), 0);
        chk(wr_strobe == 1'b0, "R1 strobe", int'(wr_strobe), 0);
        wr_en = 1'b0;
        rst_n = 1'b1;
        // R2: first edge after release sets the flag
        step(1'b0, '0, "R2 room after release");
        chk(wr_room == 1'b1, "R2 room", int'(wr_room), 1);
        // R5: fill to the last word
        for (int i = 0; i < DEPTH; i++) step(1'b1, '0, "R5 fill");
        chk(wr_room == 1'b0, "R5 full", int'(wr_room), 0);
        chk(wr_ptr == PW'(DEPTH), "R5 ptr", int'(wr_ptr), DEPTH);
        // R6: requests while full are ignored
        for (int i = 0; i < 3; i++) step(1'b1, '0, "R6 blocked");
        chk(wr_ptr == PW'(DEPTH), "R6 ptr hold", int'(wr_ptr), DEPTH);
        // R7: a read frees one location, second edge raises the flag
        step(1'b0, PW'(1), "R7 first edge");
        chk(wr_room == 1'b0, "R7 still low", int'(wr_room), 0);
        step(1'b0, PW'(1), "R7 second edge");
        chk(wr_room == 1'b1, "R7 high", int'(wr_room), 1);
        step(1'b1, PW'(1), "R5 refill");
        chk(wr_room == 1'b0, "R5 refill full", int'(wr_room), 0);
        // R8: pseudo-random sweep over all fill levels and pointer wraps
        rp = PW'(1);
        for (int i = 0; i < 4000; i++) begin
            logic we;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            we = lfsr[0] | lfsr[5];
            if (lfsr[3] && (PW'(wexp - rp) != '0)) rp = rp + PW'(1);
            step(we, rp, "R8 sweep");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule